// File: doc/BRIEF.md
# Security State Manager Controller

This block keeps the security mode of a chip and exposes it through a small register port. The mode is one of four one-hot states: inspect, secure, non-secure and fail. Software requests a mode change by writing the state register. Two health inputs decide whether entry into the secure or the non-secure mode is allowed. A request made while the matching health input is low sends the machine to fail instead of the requested mode.

A vector of security event inputs is watched in the secure and non-secure modes. Each of these two modes has its own violation mask and its own escalation mask. An event that is set in the violation mask of the current mode forces the fail state. An event that is set in the escalation mask of the current mode drives an escalation output. Each configuration field has a lock bit. Once written to 1, the lock bit holds itself and its field until reset. Leaving fail without a reset needs a restart-permission bit, and that bit can also be locked.

Top module: `ssm_ctrl`

## Requirements
- R1: After reset the state field reads inspect. The restart bit, all masks, all lock bits and the event status all read 0.
- R2: Offset 0x00 holds the state field at bits 7:4, one-hot: inspect is bit 4, secure is bit 5, non-secure is bit 6 and fail is bit 7. It also shows the live secure-health input at bit 16 and the live non-secure-health input at bit 17. All other bits read 0.
- R3: A write to offset 0x00 is a state request only when exactly one of bits 7:4 is set. A write with none or several of these bits set leaves the state unchanged.
- R4: Outside fail, a request for secure (or non-secure) moves the state there on the next edge when the matching health input is 1. When that input is 0, the request moves the state to fail. A request for inspect always succeeds, and a request for fail always succeeds.
- R5: Bit 0 of offset 0x04 is the restart-permission bit. In fail, a request for inspect leaves fail only when this bit is 1. Every other request made in fail is ignored.
- R6: Lock bits: bit 3 of 0x04 locks the restart bit. Bit 15 of 0x08 and of 0x0C locks bits 14:0 of the same register, and bit 31 locks bits 30:16. After a lock bit reads 1, writes change neither the lock bit nor the field it guards until reset.
- R7: Offset 0x08 holds the secure-mode violation mask at bits 14:0 and the non-secure-mode violation mask at bits 30:16. In secure (or non-secure) mode, an event i below 15 that is active while bit i of that mode's mask is set moves the state to fail on the next edge. This takes priority over a state request in the same cycle. Event 15 is never a violation.
- R8: Offset 0x0C uses the same layout for the escalation masks. esc_sec is high combinationally only in secure mode while an active event is selected by the secure escalation mask. esc_nsec behaves the same way for non-secure mode. The two outputs are mirrored at bits 2 and 3 of offset 0x10.
- R9: Bits 31:16 of offset 0x10 show the event inputs as sampled at the previous clock edge. Offset 0x14 shows the lifecycle input at bits 7:0. Writes to 0x10 and 0x14 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| sec_healthy | input | 1 | Secure mode may be entered |
| nsec_healthy | input | 1 | Non-secure mode may be entered |
| sec_events | input | 16 | Security event inputs |
| lifecycle | input | 8 | Lifecycle status shown read-only |
| esc_sec | output | 1 | Escalation of a secure-mode event |
| esc_nsec | output | 1 | Escalation of a non-secure-mode event |

## Verification
Two things can land on the same clock edge. One is a masked event that forces fail in secure or non-secure mode. The other is a software state request, such as a return to inspect. The bench provokes this directly by writing an inspect request while a violating event is active. It expects fail, not inspect, to be read back. The random phase also mixes sparse events, one-hot and malformed requests, and health changes into every cycle. A bench model applies the priority order, and the state, escalation outputs and register contents are compared against it at every step.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    localparam int DATA_W  = 32;
    localparam int EVT_W   = 16;
    localparam int MASK_W  = 15;
    localparam int HALF_W  = DATA_W / 2;
    localparam int NUM_FLD = 4;

    localparam logic [7:0] OFF_STATE = 8'h00;
    localparam logic [7:0] OFF_SCFG  = 8'h04;
    localparam logic [7:0] OFF_VIOL  = 8'h08;
    localparam logic [7:0] OFF_ESC   = 8'h0C;
    localparam logic [7:0] OFF_EVT   = 8'h10;
    localparam logic [7:0] OFF_LIFE  = 8'h14;

    typedef enum logic [3:0] {
        ST_INS  = 4'b0001,
        ST_SEC  = 4'b0010,
        ST_NSEC = 4'b0100,
        ST_FAIL = 4'b1000
    } ssm_state_e;

    typedef struct packed {
        logic              lock;
        logic [MASK_W-1:0] mask;
    } mask_fld_t;

    function automatic logic one_hot4(input logic [3:0] v);
        return (v != 4'b0) && ((v & (v - 4'd1)) == 4'b0);
    endfunction
endpackage

// File: rtl/ssm_lockfield.sv
module ssm_lockfield #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W:0]   wdata,
    output logic [W-1:0] val,
    output logic         lock
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lock <= 1'b0;
            val  <= '0;
        end else if (we && !lock) begin
            lock <= wdata[W];
            val  <= wdata[W-1:0];
        end
    end

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        lock |=> (lock && $stable(val)));
endmodule

// File: rtl/ssm_events.sv
module ssm_events
    import ssm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_W-1:0]  ev,
    input  ssm_state_e        state,
    input  logic [MASK_W-1:0] vio_sec,
    input  logic [MASK_W-1:0] vio_nsec,
    input  logic [MASK_W-1:0] esc_m_sec,
    input  logic [MASK_W-1:0] esc_m_nsec,
    output logic              viol,
    output logic              esc_s,
    output logic              esc_n,
    output logic [EVT_W-1:0]  ev_q
);
    logic [MASK_W-1:0] ev_m;
    assign ev_m = ev[MASK_W-1:0];

    always_comb begin
        viol  = ((state == ST_SEC)  && |(ev_m & vio_sec)) ||
                ((state == ST_NSEC) && |(ev_m & vio_nsec));
        esc_s = (state == ST_SEC)  && |(ev_m & esc_m_sec);
        esc_n = (state == ST_NSEC) && |(ev_m & esc_m_nsec);
    end

    always_ff @(posedge clk) begin
        if (rst) ev_q <= '0;
        else     ev_q <= ev;
    end

    p_esc_sec_state_r8: assert property (@(posedge clk) disable iff (rst)
        esc_s |-> (state == ST_SEC));
    p_esc_nsec_state_r8: assert property (@(posedge clk) disable iff (rst)
        esc_n |-> (state == ST_NSEC));
    p_evt_sample_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ev_q == $past(ev)));
endmodule

// File: rtl/ssm_fsm.sv
module ssm_fsm
    import ssm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_vld,
    input  logic [3:0] req,
    input  logic       sec_ok,
    input  logic       nsec_ok,
    input  logic       restart,
    input  logic       viol,
    output ssm_state_e state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_INS;
        end else if (viol) begin
            state <= ST_FAIL;
        end else if (req_vld) begin
            if (state == ST_FAIL) begin
                if (req == ST_INS && restart) state <= ST_INS;
            end else begin
                case (req)
                    ST_INS:  state <= ST_INS;
                    ST_SEC:  state <= sec_ok  ? ST_SEC  : ST_FAIL;
                    ST_NSEC: state <= nsec_ok ? ST_NSEC : ST_FAIL;
                    default: state <= ST_FAIL;
                endcase
            end
        end
    end

    p_state_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);
    p_viol_to_fail_r7: assert property (@(posedge clk) disable iff (rst)
        viol |=> (state == ST_FAIL));
    p_fail_locked_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAIL && !restart) |=> (state == ST_FAIL));
    p_deny_sec_r4: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req == ST_SEC && !sec_ok && state != ST_FAIL) |=> (state == ST_FAIL));
endmodule

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
    import ssm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sec_healthy,
    input  logic              nsec_healthy,
    input  logic [EVT_W-1:0]  sec_events,
    input  logic [7:0]        lifecycle,
    output logic              esc_sec,
    output logic              esc_nsec
);
    logic [7:0] off;
    assign off = 8'(reg_addr);

    // Configuration fields: 0 = secure violation, 1 = non-secure violation,
    // 2 = secure escalation, 3 = non-secure escalation.
    mask_fld_t fld [NUM_FLD];

    for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
        localparam logic [7:0] FOFF = (g < 2) ? OFF_VIOL : OFF_ESC;
        localparam int         LSB  = (g % 2) * HALF_W;
        ssm_lockfield #(.W(MASK_W)) u_fld (
            .clk   (clk),
            .rst   (rst),
            .we    (reg_wr && off == FOFF),
            .wdata (reg_wdata[LSB +: HALF_W]),
            .val   (fld[g].mask),
            .lock  (fld[g].lock)
        );
    end

    logic restart, restart_lock;
    ssm_lockfield #(.W(1)) u_restart (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_wr && off == OFF_SCFG),
        .wdata ({reg_wdata[3], reg_wdata[0]}),
        .val   (restart),
        .lock  (restart_lock)
    );

    ssm_state_e       state;
    logic             viol;
    logic [EVT_W-1:0] ev_q;
    logic             req_vld;

    assign req_vld = reg_wr && off == OFF_STATE && one_hot4(reg_wdata[7:4]);

    ssm_events u_evt (
        .clk        (clk),
        .rst        (rst),
        .ev         (sec_events),
        .state      (state),
        .vio_sec    (fld[0].mask),
        .vio_nsec   (fld[1].mask),
        .esc_m_sec  (fld[2].mask),
        .esc_m_nsec (fld[3].mask),
        .viol       (viol),
        .esc_s      (esc_sec),
        .esc_n      (esc_nsec),
        .ev_q       (ev_q)
    );

    ssm_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req_vld (req_vld),
        .req     (reg_wdata[7:4]),
        .sec_ok  (sec_healthy),
        .nsec_ok (nsec_healthy),
        .restart (restart),
        .viol    (viol),
        .state   (state)
    );

    always_comb begin
        reg_rdata = '0;
        case (off)
            OFF_STATE: reg_rdata = {14'b0, nsec_healthy, sec_healthy, 8'b0, state, 4'b0};
            OFF_SCFG:  reg_rdata = {28'b0, restart_lock, 2'b0, restart};
            OFF_VIOL:  reg_rdata = {fld[1], fld[0]};
            OFF_ESC:   reg_rdata = {fld[3], fld[2]};
            OFF_EVT:   reg_rdata = {ev_q, 12'b0, esc_nsec, esc_sec, 2'b0};
            OFF_LIFE:  reg_rdata = {24'b0, lifecycle};
            default:   reg_rdata = '0;
        endcase
    end

    p_restart_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        restart_lock |=> (restart_lock && $stable(restart)));
endmodule

// File: tb/tb_ssm_ctrl.sv
module tb_ssm_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sec_healthy = 1'b0, nsec_healthy = 1'b0;
    logic [15:0] sec_events = '0;
    logic [7:0]  lifecycle = 8'h0;
    logic        esc_sec, esc_nsec;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ssm_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sec_healthy(sec_healthy), .nsec_healthy(nsec_healthy),
        .sec_events(sec_events), .lifecycle(lifecycle),
        .esc_sec(esc_sec), .esc_nsec(esc_nsec)
    );

    // Bench model of the requirements
    logic [3:0]  ms;
    logic        mrs, mrl;
    logic [14:0] mmask [4];
    logic        mlk [4];
    logic [15:0] mevq;

    localparam logic [3:0] S_INS = 4'b0001, S_SEC = 4'b0010, S_NSEC = 4'b0100, S_FAIL = 4'b1000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_esc(input logic sec);
        if (sec) return ms == S_SEC && |(sec_events[14:0] & mmask[2]);
        return ms == S_NSEC && |(sec_events[14:0] & mmask[3]);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return {14'b0, nsec_healthy, sec_healthy, 8'b0, ms, 4'b0};
            8'h04: return {28'b0, mrl, 2'b0, mrs};
            8'h08: return {mlk[1], mmask[1], mlk[0], mmask[0]};
            8'h0C: return {mlk[3], mmask[3], mlk[2], mmask[2]};
            8'h10: return {mevq, 12'b0, exp_esc(1'b0), exp_esc(1'b1), 2'b0};
            8'h14: return {24'b0, lifecycle};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00: return "R2";
            8'h04: return "R5";
            8'h08: return "R7";
            8'h0C: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [3:0] next_state(input logic w, input logic [7:0] a, input logic [31:0] d);
        logic [3:0] rq;
        if (ms == S_SEC  && |(sec_events[14:0] & mmask[0])) return S_FAIL;
        if (ms == S_NSEC && |(sec_events[14:0] & mmask[1])) return S_FAIL;
        rq = d[7:4];
        if (!(w && a == 8'h00 && $countones(rq) == 1)) return ms;
        if (ms == S_FAIL) return (rq == S_INS && mrs) ? S_INS : S_FAIL;
        case (rq)
            S_SEC:   return sec_healthy  ? S_SEC  : S_FAIL;
            S_NSEC:  return nsec_healthy ? S_NSEC : S_FAIL;
            S_INS:   return S_INS;
            default: return S_FAIL;
        endcase
    endfunction

    task automatic model_reset();
        ms = S_INS; mrs = 0; mrl = 0; mevq = '0;
        for (int i = 0; i < 4; i++) begin mmask[i] = '0; mlk[i] = 0; end
    endtask

    task automatic do_reset();
        rst = 1'b1; reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // One cycle: drive at negedge, check combinational outputs, clock, update model.
    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [15:0] e);
        logic [3:0] nst;
        reg_wr = w; reg_addr = a; reg_wdata = d; sec_events = e;
        #1;
        chk("R8 esc_sec", {31'b0, esc_sec}, {31'b0, exp_esc(1'b1)});
        chk("R8 esc_nsec", {31'b0, esc_nsec}, {31'b0, exp_esc(1'b0)});
        chk(tag_of(a), reg_rdata, exp_rd(a));
        nst = next_state(w, a, d);
        @(posedge clk);
        ms = nst;
        mevq = e;
        if (w && a == 8'h04 && !mrl) begin mrl = d[3]; mrs = d[0]; end
        for (int i = 0; i < 4; i++) begin
            if (w && a == ((i < 2) ? 8'h08 : 8'h0C) && !mlk[i]) begin
                mlk[i]   = (i % 2) ? d[31] : d[15];
                mmask[i] = (i % 2) ? d[30:16] : d[14:0];
            end
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        @(negedge clk);
        do_reset();

        // R1 reset values
        rdchk("R1 state", 8'h00, 32'h0000_0010);
        rdchk("R1 scfg",  8'h04, 32'h0);
        rdchk("R1 viol",  8'h08, 32'h0);
        rdchk("R1 esc",   8'h0C, 32'h0);
        rdchk("R1 evt",   8'h10, 32'h0);
        // R2 live health flags
        sec_healthy = 1'b1;
        rdchk("R2 health", 8'h00, 32'h0001_0010);
        sec_healthy = 1'b0; nsec_healthy = 1'b1;
        rdchk("R2 health", 8'h00, 32'h0002_0010);
        nsec_healthy = 1'b0;

        // R3 malformed requests ignored
        step(1, 8'h00, 32'h30, 0);
        rdchk("R3 two bits", 8'h00, 32'h10);
        step(1, 8'h00, 32'h0, 0);
        rdchk("R3 no bit", 8'h00, 32'h10);

        // R4 denied entry goes to fail
        step(1, 8'h00, 32'h20, 0);
        rdchk("R4 deny", 8'h00, 32'h80);
        // R5 no restart permission
        step(1, 8'h00, 32'h10, 0);
        rdchk("R5 stuck", 8'h00, 32'h80);
        step(1, 8'h04, 32'h1, 0);
        step(1, 8'h00, 32'h20, 0);
        rdchk("R5 sec ignored", 8'h00, 32'h80);
        step(1, 8'h00, 32'h10, 0);
        rdchk("R5 restart", 8'h00, 32'h10);
        // R4 allowed entry
        sec_healthy = 1'b1;
        step(1, 8'h00, 32'h20, 0);
        rdchk("R4 enter sec", 8'h00, 32'h0001_0020);

        // R7 violation beats a same-cycle inspect request
        step(1, 8'h08, 32'h0000_0008, 0);
        step(1, 8'h00, 32'h10, 16'h0008);
        rdchk("R7 priority", 8'h00, 32'h0001_0080);
        step(1, 8'h00, 32'h10, 0);

        // R8 escalation in non-secure mode only
        step(1, 8'h0C, 32'h0002_0004, 0);
        nsec_healthy = 1'b1;
        step(1, 8'h00, 32'h40, 0);
        reg_addr = 8'h10; sec_events = 16'h0006; #1;
        chk("R8 nsec out", {30'b0, esc_nsec, esc_sec}, 32'h2);
        chk("R8 mirror", reg_rdata & 32'hC, 32'h8);
        step(0, 8'h10, 32'h0, 16'h0006);

        // R6 lock bits
        step(1, 8'h04, 32'h9, 0);
        step(1, 8'h04, 32'h0, 0);
        rdchk("R6 scfg locked", 8'h04, 32'h9);
        step(1, 8'h08, 32'h8001_0000, 0);
        step(1, 8'h08, 32'h0000_0000, 0);
        rdchk("R6 half locked", 8'h08, 32'h8001_0000);

        // R9 status, lifecycle, writes to read-only offsets
        lifecycle = 8'hA5;
        step(1, 8'h14, 32'hFFFF_FFFF, 16'h8000);
        rdchk("R9 life", 8'h14, 32'h0000_00A5);
        rdchk("R9 evt", 8'h10, 32'h8000_0000);
        rdchk("R7 evt15 no viol", 8'h00, 32'h0003_0040);

        // Random phase
        for (int blk = 0; blk < 4; blk++) begin
            do_reset();
            for (int it = 0; it < 400; it++) begin
                logic [7:0]  a;
                logic [31:0] d;
                logic [15:0] e;
                int sel;
                sec_healthy  = ($urandom % 4) != 0;
                nsec_healthy = ($urandom % 4) != 0;
                sel = $urandom % 8;
                a = (sel < 3) ? 8'h00 : 8'((sel - 2) * 4);
                d = $urandom;
                if (a == 8'h00) begin
                    case ($urandom % 7)
                        0: d = 32'h10; 1: d = 32'h20; 2: d = 32'h40;
                        3: d = 32'h80; 4: d = 32'h30; 5: d = 32'h0;
                        default: d = $urandom;
                    endcase
                end else if ($urandom % 8 != 0) begin
                    d = d & 32'h7FFF_7FF7;
                end
                e = 16'($urandom & $urandom & $urandom);
                step(($urandom % 4) != 0, a, d, e);
            end
            rdchk("R2 final", 8'h00, exp_rd(8'h00));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule